// File: doc/BRIEF.md
# Indexed Byte-Wide NVRAM Access Port

This block gives a host a narrow, indexed path into a battery-backed byte store. The host never presents a full address on the bus. It loads a 16-bit pointer with two byte writes, low half first and then high half, and then moves one byte through a separate data offset. Each data write consumes the pointer: after the byte is stored, the pointer returns to zero. Data reads leave the pointer where it is.

Two 16-byte windows, at 0x20 and at 0x30, can be write-protected and hidden. Each window has its own lock bit. The lock input flips the chosen bit rather than setting it. While a window is locked, writes into it are dropped and reads from it return all ones. The store itself is held inside the block.

The top EXT_SPAN bytes of the address space hold clock and calendar registers. These are not part of this block. Accesses that land there are passed to an external register port, and the byte that port returns is used as the read data. Pointer values at or above the store size read as all ones, and writes to them are dropped. A reset clears the pointer and the locks. A reset does not clear the stored bytes.

Top module: `nvram_index_port`

## Requirements
- R1: A write to offset 0 loads pointer bits 7:0 and keeps pointer bits 15:8.
- R2: A write to offset 1 loads pointer bits 15:8 and keeps pointer bits 7:0.
- R3: A write to offset 3 stores the byte at the pointer and then clears the pointer to 0x0000.
- R4: A read strobe at offset 3 presents the byte at the pointer on `reg_rdata` one clock later. The pointer does not change. `reg_rdata` holds its value until the next read strobe.
- R5: A `lock_tgl` pulse inverts lock bit `lock_sel`. Bit 0 guards addresses 0x20..0x2F and bit 1 guards addresses 0x30..0x3F.
- R6: While a window is locked, writes into it leave the store unchanged and reads from it return 0xFF. The pointer still clears after such a write.
- R7: At pointer values at or above MEM_BYTES, reads return 0xFF and writes change nothing.
- R8: Pointer values from MEM_BYTES-EXT_SPAN up to MEM_BYTES-1 go to the external port. A data write raises `ext_wr` for that cycle and a data read raises `ext_rd`, in both cases with `ext_addr` equal to the pointer. The read returns `ext_rdata`. The internal store is not used.
- R9: A read of offsets 0, 1 or 2 returns 0xFF. A write to offset 2 has no effect.
- R10: Reset clears the pointer to 0x0000, clears both lock bits and sets `reg_rdata` to 0x00. Stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_ofs | input | 2 | Port offset: 0 = pointer low, 1 = pointer high, 3 = data |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Read byte, valid one cycle after `reg_rd` |
| lock_tgl | input | 1 | Toggle pulse for one lock bit |
| lock_sel | input | 1 | Index of the lock bit to toggle |
| ext_wr | output | 1 | Write strobe to the external register port |
| ext_rd | output | 1 | Read strobe to the external register port |
| ext_addr | output | 16 | Pointer value for the external access |
| ext_wdata | output | 8 | Byte for an external write |
| ext_rdata | input | 8 | Byte returned by the external port during `ext_rd` |

## Verification
The embedded assertions watch these rules on every clock:
- the pointer clears after a data write;
- one pointer half stays stable while the other half is written;
- each lock bit flips on a toggle pulse and holds otherwise;
- locked, out-of-range and non-data reads return 0xFF;
- external strobes are exclusive and only cover the top window;
- read data holds between strobes.

Only the bench's scenarios can show that a byte actually reaches the store and survives. This covers writes dropped under a lock, the value that comes back after a lock is released, and contents that persist across reset. A behavioural reference model checks these, using the port pins alone.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;

  localparam int PTR_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ALL_ONES = 8'hFF;

  typedef enum logic [1:0] {
    OFS_PTR_LO = 2'd0,
    OFS_PTR_HI = 2'd1,
    OFS_SPARE  = 2'd2,
    OFS_DATA   = 2'd3
  } port_ofs_e;

  typedef enum logic [1:0] {
    RSRC_ONES  = 2'd0,
    RSRC_STORE = 2'd1,
    RSRC_EXT   = 2'd2
  } rd_src_e;

endpackage

// File: rtl/nvram_ptr_latch.sv
module nvram_ptr_latch
  import nvram_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              clr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr_o
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = lo_we | hi_we | clr;
    if (clr) begin
      ptr_d = '0;
    end else if (lo_we) begin
      ptr_d[BYTE_W-1:0] = wdata;
    end else if (hi_we) begin
      ptr_d[PTR_W-1:BYTE_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_o == '0));

  assert_lo_keeps_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !clr) |=> (ptr_o[PTR_W-1:BYTE_W] == $past(ptr_o[PTR_W-1:BYTE_W])));

  assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !clr && !lo_we) |=> (ptr_o[BYTE_W-1:0] == $past(ptr_o[BYTE_W-1:0])));

endmodule

// File: rtl/nvram_lock_ctrl.sv
module nvram_lock_ctrl
  import nvram_port_pkg::*;
#(
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int SEL_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl,
  input  logic [SEL_W-1:0] sel,
  input  logic [PTR_W-1:0] ptr,
  output logic             blocked
);

  logic [NUM_LOCKS-1:0] lock_q;
  logic [NUM_LOCKS-1:0] lock_d;
  logic [NUM_LOCKS-1:0] hit;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_win
    localparam logic [PTR_W-1:0] WinLo = PTR_W'(LOCK_BASE + g * LOCK_SPAN);
    localparam logic [PTR_W-1:0] WinHi = PTR_W'(LOCK_BASE + (g + 1) * LOCK_SPAN);
    localparam logic [SEL_W-1:0] MyIdx = SEL_W'(g);

    assign hit[g]    = (ptr >= WinLo) && (ptr < WinHi);
    assign lock_d[g] = (tgl && (sel == MyIdx)) ? ~lock_q[g] : lock_q[g];

    assert_lock_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl && sel == MyIdx) |=> (lock_q[g] != $past(lock_q[g])));

    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(tgl && sel == MyIdx) |=> $stable(lock_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (tgl) begin
      lock_q <= lock_d;
    end
  end

  assign blocked = |(hit & lock_q);

endmodule

// File: rtl/nvram_store.sv
module nvram_store
  import nvram_port_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  localparam int IDX_W = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] cells [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[widx] <= wdata;
    end
  end

  assign rdata = cells[ridx];

endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvram_port_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int EXT_SPAN  = 16,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  parameter int NUM_LOCKS = 2,
  localparam int SEL_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_ofs,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             lock_tgl,
  input  logic [SEL_W-1:0] lock_sel,
  output logic             ext_wr,
  output logic             ext_rd,
  output logic [15:0]      ext_addr,
  output logic [7:0]       ext_wdata,
  input  logic [7:0]       ext_rdata
);

  localparam int IDX_W = $clog2(MEM_BYTES);
  localparam logic [PTR_W:0] MemEnd  = (PTR_W+1)'(MEM_BYTES);
  localparam logic [PTR_W:0] ExtBase = (PTR_W+1)'(MEM_BYTES - EXT_SPAN);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync_q[1];

  // offset decode
  port_ofs_e ofs;
  logic      is_data;
  logic      data_wr;
  logic      data_rd;

  assign ofs     = port_ofs_e'(reg_ofs);
  assign is_data = (ofs == OFS_DATA);
  assign data_wr = reg_wr && is_data;
  assign data_rd = reg_rd && is_data;

  // pointer latch
  logic [PTR_W-1:0] ptr;

  nvram_ptr_latch u_ptr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .lo_we (reg_wr && ofs == OFS_PTR_LO),
    .hi_we (reg_wr && ofs == OFS_PTR_HI),
    .clr   (data_wr),
    .wdata (reg_wdata),
    .ptr_o (ptr)
  );

  // lock windows
  logic blocked;

  nvram_lock_ctrl #(
    .NUM_LOCKS (NUM_LOCKS),
    .LOCK_BASE (LOCK_BASE),
    .LOCK_SPAN (LOCK_SPAN)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tgl     (lock_tgl),
    .sel     (lock_sel),
    .ptr     (ptr),
    .blocked (blocked)
  );

  // address classification
  logic in_range;
  logic in_ext;
  logic in_store;

  assign in_range = ({1'b0, ptr} < MemEnd);
  assign in_ext   = in_range && ({1'b0, ptr} >= ExtBase) && !blocked;
  assign in_store = in_range && !in_ext && !blocked;

  // byte store
  logic [BYTE_W-1:0] store_rdata;

  nvram_store #(
    .MEM_BYTES (MEM_BYTES)
  ) u_store (
    .clk   (clk),
    .we    (data_wr && in_store),
    .widx  (ptr[IDX_W-1:0]),
    .wdata (reg_wdata),
    .ridx  (ptr[IDX_W-1:0]),
    .rdata (store_rdata)
  );

  // external register port
  assign ext_wr    = data_wr && in_ext;
  assign ext_rd    = data_rd && in_ext;
  assign ext_addr  = ptr;
  assign ext_wdata = reg_wdata;

  // read path: one register stage
  rd_src_e           rsrc;
  logic [BYTE_W-1:0] rdata_d;
  logic [BYTE_W-1:0] rdata_q;

  always_comb begin
    rsrc = RSRC_ONES;
    if (is_data && in_ext) begin
      rsrc = RSRC_EXT;
    end else if (is_data && in_store) begin
      rsrc = RSRC_STORE;
    end
    unique case (rsrc)
      RSRC_EXT:   rdata_d = ext_rdata;
      RSRC_STORE: rdata_d = store_rdata;
      default:    rdata_d = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !reg_rd |=> $stable(reg_rdata));

  assert_locked_ones_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (data_rd && blocked) |=> (reg_rdata == ALL_ONES));

  assert_far_ones_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (data_rd && !in_range) |=> (reg_rdata == ALL_ONES));

  assert_ext_window_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ext_wr || ext_rd) |-> (({1'b0, ext_addr} >= ExtBase) && ({1'b0, ext_addr} < MemEnd)));

  assert_ext_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(reg_wr && reg_rd) |-> $onehot0({ext_wr, ext_rd}));

  assert_spare_ones_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_rd && !is_data) |=> (reg_rdata == ALL_ONES));

endmodule

// File: tb/nvram_index_port_bench.sv
module nvram_index_port_bench;

  localparam int MEMB = 1024;
  localparam int EXTS = 16;
  localparam int EXTB = MEMB - EXTS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_ofs = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       lock_tgl = 1'b0;
  logic [0:0] lock_sel = 1'b0;
  logic       ext_wr;
  logic       ext_rd;
  logic [15:0] ext_addr;
  logic [7:0] ext_wdata;
  logic [7:0] ext_rdata;

  always #2.5 clk = ~clk;

  assign ext_rdata = ext_addr[7:0] ^ 8'h5A;

  nvram_index_port #(.MEM_BYTES(MEMB), .EXT_SPAN(EXTS)) u_nvram_index_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_tgl(lock_tgl), .lock_sel(lock_sel),
    .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  // behavioural reference model
  int        m_ptr = 0;
  bit [1:0]  m_lock = 2'b00;
  byte       m_mem [int];
  bit [7:0]  m_rdata = 8'h00;
  int        checks = 0;
  int        errors = 0;
  bit        cmp_on = 1'b0;
  string     cur_req = "R10";

  function automatic bit m_locked(int a);
    return (m_lock[0] && a >= 32 && a < 48) || (m_lock[1] && a >= 48 && a < 64);
  endfunction

  function automatic bit m_is_ext(int a);
    return !m_locked(a) && a >= EXTB && a < MEMB;
  endfunction

  function automatic bit [7:0] m_read(int ofs, int a);
    if (ofs != 3 || m_locked(a) || a >= MEMB) return 8'hFF;
    if (a >= EXTB) return 8'(a) ^ 8'h5A;
    return m_mem.exists(a) ? 8'(m_mem[a]) : 8'hEE;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_lock = 2'b00; m_rdata = 8'h00;
    end else begin
      if (reg_rd) m_rdata = m_read(int'(reg_ofs), m_ptr);
      if (lock_tgl) m_lock[lock_sel] = ~m_lock[lock_sel];
      if (reg_wr) begin
        case (reg_ofs)
          2'd0: m_ptr = (m_ptr & 16'hFF00) | int'(reg_wdata);
          2'd1: m_ptr = (m_ptr & 16'h00FF) | (int'(reg_wdata) << 8);
          2'd3: begin
            if (!m_locked(m_ptr) && m_ptr < EXTB) m_mem[m_ptr] = byte'(reg_wdata);
            m_ptr = 0;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic step(bit wr, bit rd, int ofs, bit [7:0] wd, bit tg, bit sl);
    bit ew, er;
    @(negedge clk);
    if (cmp_on) begin
      checks++;
      if (reg_rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s reg_rdata actual %02h expected %02h", cur_req, reg_rdata, m_rdata);
      end
    end
    reg_wr = wr; reg_rd = rd; reg_ofs = 2'(ofs); reg_wdata = wd; lock_tgl = tg; lock_sel = sl;
    #1;
    if (cmp_on) begin
      ew = rst_n && wr && ofs == 3 && m_is_ext(m_ptr);
      er = rst_n && rd && ofs == 3 && m_is_ext(m_ptr);
      checks++;
      if (ext_wr !== ew || ext_rd !== er ||
          ((ew || er) && ext_addr !== 16'(m_ptr)) || (ew && ext_wdata !== wd)) begin
        errors++;
        $display("FAIL %s ext wr/rd/addr actual %0b/%0b/%04h expected %0b/%0b/%04h",
                 cur_req, ext_wr, ext_rd, ext_addr, ew, er, 16'(m_ptr));
      end
    end
  endtask

  task automatic idle();            step(0, 0, 0, 8'h00, 0, 0); endtask
  task automatic wr(int o, bit [7:0] d); step(1, 0, o, d, 0, 0); endtask
  task automatic rd(int o);          step(0, 1, o, 8'h00, 0, 0); endtask
  task automatic tgl(bit s);         step(0, 0, 0, 8'h00, 1, s); endtask
  task automatic set_ptr(int a);     wr(0, 8'(a)); wr(1, 8'(a >> 8)); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after 20000 cycles");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    idle();
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle();

    // seed byte 0 and byte 5
    cur_req = "R3";
    set_ptr(0);      wr(3, 8'h33);
    set_ptr(5);      wr(3, 8'h5C);
    cur_req = "R1";
    set_ptr(16'h0105); wr(3, 8'hA1);
    wr(1, 8'h02); wr(0, 8'h10); wr(0, 8'h11); wr(3, 8'hB2);   // lands at 0x0211
    cur_req = "R4";
    set_ptr(16'h0211); rd(3); rd(3); idle(); idle();
    cur_req = "R2";
    wr(0, 8'h05); wr(1, 8'h01); rd(3);     // 0x0105 -> A1
    wr(1, 8'h00); rd(3); idle();           // 0x0005 -> 5C
    cur_req = "R3";
    set_ptr(16'h0211); wr(3, 8'hC4); rd(3); idle();   // pointer cleared -> byte 0

    // R5 R6 locks
    cur_req = "R5";
    set_ptr(16'h0025); wr(3, 8'h77);
    set_ptr(16'h0035); wr(3, 8'h88);
    tgl(0);
    cur_req = "R6";
    set_ptr(16'h0025); wr(3, 8'h99); rd(3);    // cleared pointer -> 33
    set_ptr(16'h0025); rd(3);                  // locked -> FF
    set_ptr(16'h0035); rd(3);                  // open -> 88
    cur_req = "R5";
    tgl(1); rd(3);                             // now locked -> FF
    tgl(0); set_ptr(16'h0025); rd(3); idle();  // 77 kept

    cur_req = "R7";
    set_ptr(16'h0800); wr(3, 8'h12);
    set_ptr(16'h0800); rd(3);
    set_ptr(16'h1FF0); rd(3);
    set_ptr(16'h0000); rd(3); idle();

    cur_req = "R8";
    set_ptr(16'h03F3); wr(3, 8'h44);
    set_ptr(16'h03FF); rd(3);
    set_ptr(16'h03F0); rd(3);
    set_ptr(16'h03EF); wr(3, 8'h6D);
    set_ptr(16'h03EF); rd(3); idle();

    cur_req = "R9";
    set_ptr(16'h0211);
    rd(0); rd(1); rd(2);
    wr(2, 8'h00); rd(3); idle();

    cur_req = "R10";
    set_ptr(16'h0105);
    do_reset();
    rd(3);                                     // pointer 0 -> 33
    set_ptr(16'h0035); rd(3);                  // lock 1 cleared -> 88
    set_ptr(16'h0005); rd(3); idle(); idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule